// File: doc/BRIEF.md
# Switch-Selected Video Test Pattern Generator

This block colours each pixel of a raster with a test pattern. A timing generator upstream supplies the current column and row, an active-video flag and the two sync strobes. The block returns one 24-bit RGB word per clock. The sync strobes and the active flag come out delayed by the same single register stage as the colour, so the four outputs stay aligned.

An 8-bit switch word controls the picture. Its low nibble picks one of ten patterns: four solid fills, three line grids, two bar patterns and a checkerboard. Its high nibble enlarges the features in steps of eight pixels, on top of a base size that arrives on a separate input. Outside the active area the colour is always black.

Top module: `testpat_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge.
- R2: `out_de`, `out_hs` and `out_vs` equal `in_de`, `in_hs` and `in_vs` of the previous clock. `out_rgb` carries the colour for the inputs of the previous clock.
- R3: When `in_de` is low, `out_rgb` is 24'h000000 one clock later, whatever the pattern.
- R4: `out_rgb` is packed as {red[23:16], green[15:8], blue[7:0]}. Codes 0, 1, 2 and 3 on `sw[3:0]` give 000000, FF0000, 00FF00 and 0000FF across the whole active area.
- R5: The feature size S is `base_size + 8*sw[7:4]`. When that sum is zero, S is 1.
- R6: Code 4 is white (FFFFFF) on rows where y mod S is 0. Code 5 is white on columns where x mod S is 0. Code 6 is white where either holds. All three are black elsewhere.
- R7: Code 7 is white where floor(y/S) is even. Code 8 is white where floor(x/S) is even. Both are black elsewhere.
- R8: Code 9 is white where floor(x/S) XOR floor(y/S) is odd, and black elsewhere.
- R9: Codes 10 to 15 give black in the active area.
- R10: Every colour output is one of 000000, FFFFFF, FF0000, 00FF00 or 0000FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sw | input | 8 | [3:0] pattern code, [7:4] size step count |
| base_size | input | SIZE_W | Base feature size in pixels |
| in_x | input | COORD_W | Current column |
| in_y | input | COORD_W | Current row |
| in_de | input | 1 | Active-video flag |
| in_hs | input | 1 | Horizontal sync strobe |
| in_vs | input | 1 | Vertical sync strobe |
| out_rgb | output | 24 | Registered pixel colour |
| out_de | output | 1 | Active flag delayed one clock |
| out_hs | output | 1 | Horizontal sync delayed one clock |
| out_vs | output | 1 | Vertical sync delayed one clock |

## Verification
The bench builds the block with its defaults: 12-bit coordinates and an 8-bit base size. With these widths, columns and rows above 1919 and feature sizes up to 375 pixels are all reachable. Three size cases are used. A zero base with a zero step count gives the one-pixel minimum. A small base of 5 with a step count of 2 gives S = 21, which places line and bar edges at rows 21 and 42. A base of 41 probes the checkerboard corners. Coordinates are placed on each side of block edges, so an off-by-one in the remainder or the quotient shows up in the colour.

// File: rtl/testpat_pkg.sv
package testpat_pkg;

  typedef enum logic [3:0] {
    PAT_BLACK  = 4'd0,
    PAT_RED    = 4'd1,
    PAT_GREEN  = 4'd2,
    PAT_BLUE   = 4'd3,
    PAT_HLINE  = 4'd4,
    PAT_VLINE  = 4'd5,
    PAT_GRID   = 4'd6,
    PAT_HBAR   = 4'd7,
    PAT_VBAR   = 4'd8,
    PAT_CHECK  = 4'd9
  } pat_code_e;

  localparam logic [23:0] RGB_BLACK = 24'h000000;
  localparam logic [23:0] RGB_WHITE = 24'hFFFFFF;
  localparam logic [23:0] RGB_RED   = 24'hFF0000;
  localparam logic [23:0] RGB_GREEN = 24'h00FF00;
  localparam logic [23:0] RGB_BLUE  = 24'h0000FF;

endpackage

// File: rtl/testpat_size.sv
module testpat_size #(
  parameter int SIZE_W = 8,
  parameter int EFF_W  = 10
) (
  input  logic [SIZE_W-1:0] base_size,
  input  logic [3:0]        step,
  output logic [EFF_W-1:0]  eff_size
);
  logic [EFF_W-1:0] sum;

  always_comb begin
    sum = EFF_W'(base_size) + EFF_W'({step, 3'b000});
    eff_size = (sum == '0) ? EFF_W'(1) : sum;
  end
endmodule

// File: rtl/testpat_axis.sv
module testpat_axis #(
  parameter int COORD_W = 12,
  parameter int EFF_W   = 10
) (
  input  logic [COORD_W-1:0] coord,
  input  logic [EFF_W-1:0]   size,
  output logic               on_line,
  output logic               odd_blk
);
  localparam int DW = (COORD_W > EFF_W) ? COORD_W : EFF_W;

  logic [DW-1:0] c_ext, s_ext, quo, rem;

  always_comb begin
    c_ext   = DW'(coord);
    s_ext   = DW'(size);
    quo     = c_ext / s_ext;
    rem     = c_ext % s_ext;
    on_line = (rem == '0);
    odd_blk = quo[0];
  end
endmodule

// File: rtl/testpat_shade.sv
module testpat_shade
  import testpat_pkg::*;
(
  input  logic [3:0]  code,
  input  logic        x_line,
  input  logic        y_line,
  input  logic        x_odd,
  input  logic        y_odd,
  output logic [23:0] rgb
);
  always_comb begin
    case (code)
      PAT_BLACK: rgb = RGB_BLACK;
      PAT_RED:   rgb = RGB_RED;
      PAT_GREEN: rgb = RGB_GREEN;
      PAT_BLUE:  rgb = RGB_BLUE;
      PAT_HLINE: rgb = y_line ? RGB_WHITE : RGB_BLACK;
      PAT_VLINE: rgb = x_line ? RGB_WHITE : RGB_BLACK;
      PAT_GRID:  rgb = (x_line | y_line) ? RGB_WHITE : RGB_BLACK;
      PAT_HBAR:  rgb = y_odd ? RGB_BLACK : RGB_WHITE;
      PAT_VBAR:  rgb = x_odd ? RGB_BLACK : RGB_WHITE;
      PAT_CHECK: rgb = (x_odd ^ y_odd) ? RGB_WHITE : RGB_BLACK;
      default:   rgb = RGB_BLACK;
    endcase
  end
endmodule

// File: rtl/testpat_gen.sv
module testpat_gen #(
  parameter int COORD_W = 12,
  parameter int SIZE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         sw,
  input  logic [SIZE_W-1:0]  base_size,
  input  logic [COORD_W-1:0] in_x,
  input  logic [COORD_W-1:0] in_y,
  input  logic               in_de,
  input  logic               in_hs,
  input  logic               in_vs,
  output logic [23:0]        out_rgb,
  output logic               out_de,
  output logic               out_hs,
  output logic               out_vs
);
  localparam int EFF_W = (SIZE_W > 7) ? SIZE_W + 2 : 9;
  localparam int N_AX  = 2;

  logic [EFF_W-1:0]   eff_size;
  logic [COORD_W-1:0] ax_coord [N_AX];
  logic [N_AX-1:0]    ax_line, ax_odd;
  logic [23:0]        pix;

  assign ax_coord[0] = in_x;
  assign ax_coord[1] = in_y;

  testpat_size #(.SIZE_W(SIZE_W), .EFF_W(EFF_W)) u_size (
    .base_size (base_size),
    .step      (sw[7:4]),
    .eff_size  (eff_size)
  );

  for (genvar a = 0; a < N_AX; a++) begin : g_axis
    testpat_axis #(.COORD_W(COORD_W), .EFF_W(EFF_W)) u_axis (
      .coord   (ax_coord[a]),
      .size    (eff_size),
      .on_line (ax_line[a]),
      .odd_blk (ax_odd[a])
    );
  end

  testpat_shade u_shade (
    .code   (sw[3:0]),
    .x_line (ax_line[0]),
    .y_line (ax_line[1]),
    .x_odd  (ax_odd[0]),
    .y_odd  (ax_odd[1]),
    .rgb    (pix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_rgb <= '0;
      out_de  <= 1'b0;
      out_hs  <= 1'b0;
      out_vs  <= 1'b0;
    end else begin
      out_rgb <= in_de ? pix : '0;
      out_de  <= in_de;
      out_hs  <= in_hs;
      out_vs  <= in_vs;
    end
  end
endmodule

// File: rtl/testpat_chk.sv
module testpat_chk #(
  parameter int COORD_W = 12,
  parameter int SIZE_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [7:0]         sw,
  input logic [SIZE_W-1:0]  base_size,
  input logic [COORD_W-1:0] in_x,
  input logic [COORD_W-1:0] in_y,
  input logic               in_de,
  input logic               in_hs,
  input logic               in_vs,
  input logic [23:0]        out_rgb,
  input logic               out_de,
  input logic               out_hs,
  input logic               out_vs
);
  assert_align_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_de == $past(in_de)) && (out_hs == $past(in_hs)) && (out_vs == $past(in_vs)));

  assert_blank_R3: assert property (@(posedge clk) disable iff (rst)
    !in_de |=> out_rgb == 24'h000000);

  assert_red_R4: assert property (@(posedge clk) disable iff (rst)
    (in_de && sw[3:0] == 4'd1) |=> out_rgb == 24'hFF0000);

  assert_blue_R4: assert property (@(posedge clk) disable iff (rst)
    (in_de && sw[3:0] == 4'd3) |=> out_rgb == 24'h0000FF);

  assert_reserved_R9: assert property (@(posedge clk) disable iff (rst)
    (in_de && sw[3:0] >= 4'd10) |=> out_rgb == 24'h000000);

  assert_palette_R10: assert property (@(posedge clk) disable iff (rst)
    out_de |-> (out_rgb == 24'h000000 || out_rgb == 24'hFFFFFF ||
                out_rgb == 24'hFF0000 || out_rgb == 24'h00FF00 ||
                out_rgb == 24'h0000FF));

  assert_unit_line_R5: assert property (@(posedge clk) disable iff (rst)
    (in_de && sw == 8'h04 && base_size == '0) |=> out_rgb == 24'hFFFFFF);
endmodule

bind testpat_gen testpat_chk #(.COORD_W(COORD_W), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst(rst), .sw(sw), .base_size(base_size),
  .in_x(in_x), .in_y(in_y), .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
  .out_rgb(out_rgb), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs)
);

// File: tb/testpat_gen_tb.sv
module testpat_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  sw = '0;
  logic [7:0]  base_size = '0;
  logic [11:0] in_x = '0, in_y = '0;
  logic        in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic [23:0] out_rgb;
  logic        out_de, out_hs, out_vs;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  testpat_gen #(.COORD_W(12), .SIZE_W(8)) u_dut (
    .clk(clk), .rst(rst), .sw(sw), .base_size(base_size),
    .in_x(in_x), .in_y(in_y), .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
    .out_rgb(out_rgb), .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs)
  );

  function automatic logic [23:0] ref_rgb(input int x, input int y, input bit de,
                                          input logic [7:0] s, input int bs);
    int sz;
    bit w;
    if (!de) return 24'h000000;
    sz = bs + 8 * int'(s[7:4]);
    if (sz == 0) sz = 1;
    case (s[3:0])
      4'd0: return 24'h000000;
      4'd1: return 24'hFF0000;
      4'd2: return 24'h00FF00;
      4'd3: return 24'h0000FF;
      4'd4: w = (y % sz) == 0;
      4'd5: w = (x % sz) == 0;
      4'd6: w = ((x % sz) == 0) || ((y % sz) == 0);
      4'd7: w = ((y / sz) % 2) == 0;
      4'd8: w = ((x / sz) % 2) == 0;
      4'd9: w = (((x / sz) ^ (y / sz)) & 1) == 1;
      default: w = 1'b0;
    endcase
    return w ? 24'hFFFFFF : 24'h000000;
  endfunction

  task automatic pix(input int x, input int y, input bit de, input logic [7:0] s,
                     input int bs, input string tag);
    logic [23:0] exp_v;
    exp_v = ref_rgb(x, y, de, s, bs);
    @(negedge clk);
    in_x = 12'(x); in_y = 12'(y); in_de = de; sw = s; base_size = 8'(bs);
    @(negedge clk);
    checks++;
    if (out_rgb !== exp_v) begin
      failures++;
      $display("FAIL %s x=%0d y=%0d sw=%h rgb=%h expected=%h", tag, x, y, s, out_rgb, exp_v);
    end
  endtask

  task automatic t_reset_R1;
    @(negedge clk);
    rst = 1'b1; in_de = 1'b1; in_hs = 1'b1; in_vs = 1'b1; sw = 8'h01;
    @(negedge clk);
    checks++;
    if ({out_rgb, out_de, out_hs, out_vs} !== 27'd0) begin
      failures++;
      $display("FAIL R1 outputs=%h expected=0", {out_rgb, out_de, out_hs, out_vs});
    end
    rst = 1'b0; in_hs = 1'b0; in_vs = 1'b0;
  endtask

  task automatic t_align_R2;
    logic [2:0] pat [4] = '{3'b101, 3'b010, 3'b111, 3'b000};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      {in_de, in_hs, in_vs} = pat[i];
      @(negedge clk);
      checks++;
      if ({out_de, out_hs, out_vs} !== pat[i]) begin
        failures++;
        $display("FAIL R2 de/hs/vs=%b expected=%b", {out_de, out_hs, out_vs}, pat[i]);
      end
    end
  endtask

  task automatic t_solid_R4;
    pix(100, 50, 1, 8'h00, 41, "R4 black");
    pix(100, 50, 1, 8'h01, 41, "R4 red");
    pix(1919, 0, 1, 8'h32, 41, "R4 green");
    pix(0, 1079, 1, 8'hF3, 41, "R4 blue");
  endtask

  task automatic t_blank_R3;
    pix(0, 0, 0, 8'h01, 41, "R3 red blanked");
    pix(0, 0, 0, 8'h04, 41, "R3 line blanked");
    pix(7, 3, 0, 8'h09, 0, "R3 checker blanked");
  endtask

  task automatic t_size_R5;
    pix(3, 7, 1, 8'h04, 0, "R5 unit hline");
    pix(3, 7, 1, 8'h05, 0, "R5 unit vline");
    pix(0, 1, 1, 8'h07, 0, "R5 unit hbar odd row");
    pix(0, 21, 1, 8'h24, 5, "R5 S=21 on line");
    pix(0, 20, 1, 8'h24, 5, "R5 S=21 off line");
    pix(0, 8, 1, 8'h14, 0, "R5 step only");
  endtask

  task automatic t_lines_R6;
    pix(5, 42, 1, 8'h24, 5, "R6 hline row 42");
    pix(42, 5, 1, 8'h25, 5, "R6 vline col 42");
    pix(43, 5, 1, 8'h25, 5, "R6 vline col 43");
    pix(41, 82, 1, 8'h06, 41, "R6 grid col");
    pix(40, 82, 1, 8'h06, 41, "R6 grid row");
    pix(40, 81, 1, 8'h06, 41, "R6 grid off");
  endtask

  task automatic t_bars_R7;
    pix(0, 20, 1, 8'h27, 5, "R7 hbar block0");
    pix(0, 21, 1, 8'h27, 5, "R7 hbar block1");
    pix(0, 42, 1, 8'h27, 5, "R7 hbar block2");
    pix(40, 0, 1, 8'h08, 41, "R7 vbar block0");
    pix(41, 0, 1, 8'h08, 41, "R7 vbar block1");
  endtask

  task automatic t_check_R8;
    pix(0, 0, 1, 8'h09, 41, "R8 origin");
    pix(41, 0, 1, 8'h09, 41, "R8 right");
    pix(40, 41, 1, 8'h09, 41, "R8 below");
    pix(41, 41, 1, 8'h09, 41, "R8 diagonal");
    pix(1919, 1079, 1, 8'hF9, 41, "R8 far corner");
  endtask

  task automatic t_reserved_R9;
    for (int c = 10; c < 16; c++) pix(0, 0, 1, 8'(c), 0, "R9 reserved code");
  endtask

  task automatic t_palette_R10;
    for (int c = 0; c < 10; c++) begin
      pix(13 * c, 7 * c, 1, {4'(c), 4'(c)}, 3, "R10 sweep");
      checks++;
      if (!(out_rgb inside {24'h000000, 24'hFFFFFF, 24'hFF0000, 24'h00FF00, 24'h0000FF})) begin
        failures++;
        $display("FAIL R10 rgb=%h expected palette colour", out_rgb);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_R1();
    t_align_R2();
    t_solid_R4();
    t_blank_R3();
    t_size_R5();
    t_lines_R6();
    t_bars_R7();
    t_check_R8();
    t_reserved_R9();
    t_palette_R10();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule